// File: doc/BRIEF.md
# Per-Tile Variable-Rate Refresh Scheduler

This block schedules refresh for an embedded-DRAM cache bank whose lines are grouped into tiles of adjacent lines. Each tile has its own refresh period, counted in steps, and the periods are held in a small retention-profile store. A programmable divider turns the reference clock into a periodic step tick. On each tick a sequencer walks over the tiles one per clock. It decrements each tile's counter. When a counter runs out, that tile is queued for refresh and its counter is reloaded from the profile.

Queued tiles are expanded into a stream of line addresses on a valid/ready handshake. Each tile produces every line it holds, lowest first. Two sticky flags report trouble. One is set when a step tick arrives before the previous sweep has finished. The other is set when a tile comes due again while its earlier refresh is still waiting.

With every profile entry left at one, the block reduces to a fixed-rate scheme that refreshes every line on every step.

Top module: `tile_refresh_sched`

## Requirements
- R1: After reset `req_valid`, `overrun_err` and `missed_err` are all 0, and every profile entry holds the value 1.
- R2: Step ticks occur once every `div_cfg`+1 clock cycles, so the time between refreshes of a tile scales with `div_cfg`.
- R3: A tile whose profile entry is p (1..63) is refreshed exactly once every p step ticks.
- R4: A profile entry of 0 behaves exactly like an entry of 1.
- R5: With all profile entries equal to 1, every line of the bank is requested once per step tick.
- R6: A queued tile T is issued as line addresses T*32+0 through T*32+31 in ascending order. `req_line` is the tile index in the upper bits and the line offset in the low 5 bits. While `req_valid` is high and `req_ready` is low, `req_valid` and `req_line` hold.
- R7: Tiles that expire in the same sweep are issued in ascending tile order.
- R8: A step tick arriving while a sweep is still in progress sets `overrun_err`, which stays set until reset.
- R9: A tile that expires while its earlier refresh is still queued or being issued sets `missed_err`, which stays set until reset. The duplicate is not queued again.
- R10: After reset an initialisation sweep loads all counters from the profile before any tick is honoured. As a result, the first honoured tick refreshes all tiles.
- R11: A profile write does not change a running counter. The new value takes effect at that tile's next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | DIV_W | Step divider setting; step period is div_cfg+1 cycles |
| prof_we | input | 1 | Profile write enable |
| prof_addr | input | TILE_W | Tile index to write |
| prof_data | input | CNT_W | Refresh period in steps for that tile |
| req_valid | output | 1 | A line refresh request is presented |
| req_ready | input | 1 | Consumer accepts the presented request |
| req_line | output | LINE_W | Line address to refresh |
| overrun_err | output | 1 | Sticky: a tick arrived during a sweep |
| missed_err | output | 1 | Sticky: a tile expired while still queued |

## Verification
The assertions rely on two assumptions about the inputs. First, `div_cfg` is never zero; a zero setting would produce a tick on every cycle. Second, `div_cfg` changes only to another nonzero value, so a tick is never followed directly by another. The bench drives only the settings 9, 999 and 1999. It changes profile entries and the divider only in quiet gaps after a burst of requests has drained. Refresh counts are taken over windows that start and end in those gaps, so each window covers a whole number of step periods.

// File: rtl/tile_refresh_pkg.sv
package tile_refresh_pkg;

    localparam int TR_NUM_TILES      = 16;
    localparam int TR_LINES_PER_TILE = 32;
    localparam int TR_CNT_W          = 6;
    localparam int TR_DIV_W          = 16;

    typedef enum logic [1:0] {
        SW_INIT,
        SW_IDLE,
        SW_RUN
    } sweep_state_e;

    // A stored period of zero would never expire; lift it to one step.
    function automatic logic [15:0] period_floor_one(input logic [15:0] raw);
        return (raw == 16'd0) ? 16'd1 : raw;
    endfunction

    function automatic logic [15:0] wrap_inc(input logic [15:0] v, input logic [15:0] last);
        return (v == last) ? 16'd0 : v + 16'd1;
    endfunction

endpackage

// File: rtl/trs_step_divider.sv
module trs_step_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             step_tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            step_tick <= 1'b0;
        end else if (cnt_q >= div_cfg) begin
            cnt_q     <= '0;
            step_tick <= 1'b1;
        end else begin
            cnt_q     <= cnt_q + DIV_W'(1);
            step_tick <= 1'b0;
        end
    end

    // R2: ticks are spaced by at least two cycles for any nonzero setting
    a_r2_tick_spaced: assert property (@(posedge clk) disable iff (rst)
        (step_tick && div_cfg != '0) |=> !step_tick);

endmodule

// File: rtl/trs_tile_sweeper.sv
module trs_tile_sweeper
    import tile_refresh_pkg::*;
#(
    parameter int NUM_TILES = 16,
    parameter int CNT_W     = 6,
    parameter int TILE_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_tick,
    input  logic              prof_we,
    input  logic [TILE_W-1:0] prof_addr,
    input  logic [CNT_W-1:0]  prof_data,
    output logic              exp_valid,
    output logic [TILE_W-1:0] exp_tile,
    output logic              overrun_err
);
    localparam logic [15:0] LAST_IDX = 16'(NUM_TILES - 1);

    logic [CNT_W-1:0]  prof_q [NUM_TILES];
    logic [CNT_W-1:0]  cnt_q  [NUM_TILES];
    sweep_state_e      st_q;
    logic [TILE_W-1:0] idx_q;
    logic [CNT_W-1:0]  reload_val;
    logic              idx_last;

    assign reload_val = CNT_W'(period_floor_one(16'(prof_q[idx_q])));
    assign idx_last   = (16'(idx_q) == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TILES; i++) begin
                prof_q[i] <= CNT_W'(1);
                cnt_q[i]  <= CNT_W'(1);
            end
            st_q        <= SW_INIT;
            idx_q       <= '0;
            exp_valid   <= 1'b0;
            exp_tile    <= '0;
            overrun_err <= 1'b0;
        end else begin
            exp_valid <= 1'b0;
            if (prof_we && (int'(prof_addr) < NUM_TILES))
                prof_q[prof_addr] <= prof_data;

            case (st_q)
                SW_INIT: begin
                    cnt_q[idx_q] <= reload_val;
                    idx_q        <= TILE_W'(wrap_inc(16'(idx_q), LAST_IDX));
                    if (idx_last) st_q <= SW_IDLE;
                end
                SW_IDLE: begin
                    if (step_tick) begin
                        st_q  <= SW_RUN;
                        idx_q <= '0;
                    end
                end
                SW_RUN: begin
                    if (step_tick) overrun_err <= 1'b1;
                    if (cnt_q[idx_q] <= CNT_W'(1)) begin
                        cnt_q[idx_q] <= reload_val;
                        exp_valid    <= 1'b1;
                        exp_tile     <= idx_q;
                    end else begin
                        cnt_q[idx_q] <= cnt_q[idx_q] - CNT_W'(1);
                    end
                    idx_q <= TILE_W'(wrap_inc(16'(idx_q), LAST_IDX));
                    if (idx_last) st_q <= SW_IDLE;
                end
                default: st_q <= SW_IDLE;
            endcase
        end
    end

    // R3/R4: once loaded, a visited counter is never zero
    a_r4_counter_live: assert property (@(posedge clk) disable iff (rst)
        (st_q == SW_RUN) |-> (cnt_q[idx_q] != '0));

    // R8: overrun flag is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_err |=> overrun_err);

    // R10: no expiry is produced while the init sweep runs
    a_r10_init_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == SW_INIT) |=> !exp_valid);

endmodule

// File: rtl/trs_line_expander.sv
module trs_line_expander
    import tile_refresh_pkg::*;
#(
    parameter int NUM_TILES = 16,
    parameter int TILE_W    = 4,
    parameter int OFF_W     = 5,
    parameter int LINE_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exp_valid,
    input  logic [TILE_W-1:0] exp_tile,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [LINE_W-1:0] req_line,
    output logic              missed_err
);
    localparam logic [15:0] LAST_SLOT = 16'(NUM_TILES - 1);

    logic [TILE_W-1:0]    fifo_q [NUM_TILES];
    logic [TILE_W-1:0]    wr_ptr_q, rd_ptr_q;
    logic [TILE_W:0]      used_q;
    logic [NUM_TILES-1:0] pend_q;
    logic [OFF_W-1:0]     off_q;
    logic                 fire, pop, push, dup;
    logic [TILE_W-1:0]    head_tile;

    assign head_tile = fifo_q[rd_ptr_q];
    assign req_valid = (used_q != '0);
    assign req_line  = {head_tile, off_q};
    assign fire      = req_valid && req_ready;
    assign pop       = fire && (off_q == '1);
    assign dup       = exp_valid && pend_q[exp_tile];
    assign push      = exp_valid && !pend_q[exp_tile];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TILES; i++) fifo_q[i] <= '0;
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            used_q     <= '0;
            pend_q     <= '0;
            off_q      <= '0;
            missed_err <= 1'b0;
        end else begin
            if (fire) off_q <= off_q + OFF_W'(1);
            if (pop) begin
                rd_ptr_q         <= TILE_W'(wrap_inc(16'(rd_ptr_q), LAST_SLOT));
                pend_q[head_tile] <= 1'b0;
            end
            if (push) begin
                fifo_q[wr_ptr_q] <= exp_tile;
                wr_ptr_q         <= TILE_W'(wrap_inc(16'(wr_ptr_q), LAST_SLOT));
                pend_q[exp_tile] <= 1'b1;
            end
            case ({push, pop})
                2'b10:   used_q <= used_q + (TILE_W+1)'(1);
                2'b01:   used_q <= used_q - (TILE_W+1)'(1);
                default: used_q <= used_q;
            endcase
            if (dup) missed_err <= 1'b1;
        end
    end

    // R6: a stalled request holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));

    // R6: lines of one tile advance by one
    a_r6_ascend: assert property (@(posedge clk) disable iff (rst)
        (fire && (req_line[OFF_W-1:0] != '1)) |=>
        (req_valid && req_line == LINE_W'($past(req_line) + LINE_W'(1))));

    // R9: duplicates never overfill the queue
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (int'(used_q) < NUM_TILES || pop));

    // R9: missed flag is sticky
    a_r9_missed_sticky: assert property (@(posedge clk) disable iff (rst)
        missed_err |=> missed_err);

endmodule

// File: rtl/tile_refresh_sched.sv
module tile_refresh_sched
    import tile_refresh_pkg::*;
#(
    parameter int NUM_TILES      = TR_NUM_TILES,
    parameter int LINES_PER_TILE = TR_LINES_PER_TILE,
    parameter int CNT_W          = TR_CNT_W,
    parameter int DIV_W          = TR_DIV_W,
    localparam int TILE_W        = $clog2(NUM_TILES),
    localparam int OFF_W         = $clog2(LINES_PER_TILE),
    localparam int LINE_W        = TILE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              prof_we,
    input  logic [TILE_W-1:0] prof_addr,
    input  logic [CNT_W-1:0]  prof_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [LINE_W-1:0] req_line,
    output logic              overrun_err,
    output logic              missed_err
);
    logic              step_tick;
    logic              exp_valid;
    logic [TILE_W-1:0] exp_tile;

    trs_step_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .div_cfg   (div_cfg),
        .step_tick (step_tick)
    );

    trs_tile_sweeper #(
        .NUM_TILES (NUM_TILES),
        .CNT_W     (CNT_W),
        .TILE_W    (TILE_W)
    ) u_sweep (
        .clk         (clk),
        .rst         (rst),
        .step_tick   (step_tick),
        .prof_we     (prof_we),
        .prof_addr   (prof_addr),
        .prof_data   (prof_data),
        .exp_valid   (exp_valid),
        .exp_tile    (exp_tile),
        .overrun_err (overrun_err)
    );

    trs_line_expander #(
        .NUM_TILES (NUM_TILES),
        .TILE_W    (TILE_W),
        .OFF_W     (OFF_W),
        .LINE_W    (LINE_W)
    ) u_expand (
        .clk        (clk),
        .rst        (rst),
        .exp_valid  (exp_valid),
        .exp_tile   (exp_tile),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_line   (req_line),
        .missed_err (missed_err)
    );

endmodule

// File: tb/tile_refresh_sched_tb.sv
module tile_refresh_sched_tb;
    localparam int NT = 16;
    localparam int LW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   div_cfg = 16'd999;
    logic          prof_we = 1'b0;
    logic [3:0]    prof_addr = '0;
    logic [5:0]    prof_data = '0;
    logic          req_ready = 1'b1;
    logic          req_valid;
    logic [LW-1:0] req_line;
    logic          overrun_err, missed_err;

    int checks = 0;
    int errors = 0;
    int log_q [1024];
    int log_n = 0;
    int starts [NT];
    bit done = 0;

    always #4 clk = ~clk;

    tile_refresh_sched u_dut (
        .clk(clk), .rst(rst), .div_cfg(div_cfg),
        .prof_we(prof_we), .prof_addr(prof_addr), .prof_data(prof_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .overrun_err(overrun_err), .missed_err(missed_err)
    );

    // Handshake monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst && req_valid && req_ready) begin
            if (log_n < 1024) log_q[log_n] = int'(req_line);
            log_n = log_n + 1;
            if (req_line[4:0] == 5'd0) starts[int'(req_line[8:5])] += 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_starts();
        for (int i = 0; i < NT; i++) starts[i] = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; req_ready = 1'b1; div_cfg = 16'd999; prof_we = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        log_n = 0;
        clear_starts();
    endtask

    task automatic wait_burst_end();
        int quiet;
        while (!req_valid) @(negedge clk);
        quiet = 0;
        while (quiet < 200) begin
            @(negedge clk);
            if (req_valid) quiet = 0; else quiet++;
        end
    endtask

    task automatic write_prof(input int t, input int v);
        @(posedge clk); #1;
        prof_we = 1'b1; prof_addr = 4'(t); prof_data = 6'(v);
        @(posedge clk); #1;
        prof_we = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check(req_valid == 1'b0, "R1 valid after reset", int'(req_valid), 0);
        check(overrun_err == 1'b0, "R1 overrun after reset", int'(overrun_err), 0);
        check(missed_err == 1'b0, "R1 missed after reset", int'(missed_err), 0);
    endtask

    task automatic t_baseline();
        int bad;
        do_reset();
        repeat (900) @(negedge clk);
        check(log_n == 0, "R10 no request before first tick", log_n, 0);
        while (log_n < 512) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 512; i++) if (log_q[i] != i) bad++;
        check(bad == 0, "R10/R6/R7 first burst covers all lines in order", bad, 0);
        wait_burst_end();
        clear_starts();
        repeat (3000) @(negedge clk);
        bad = 0;
        for (int i = 0; i < NT; i++) if (starts[i] != 3) bad++;
        check(bad == 0, "R5 each tile refreshed every step", starts[0], 3);
        @(posedge clk); #1 div_cfg = 16'd1999;
        wait_burst_end();
        clear_starts();
        repeat (6000) @(negedge clk);
        bad = 0;
        for (int i = 0; i < NT; i++) if (starts[i] != 3) bad++;
        check(bad == 0, "R2 doubled divider halves refresh rate", starts[0], 3);
        check(overrun_err == 1'b0, "R8 no overrun at slow ticks", int'(overrun_err), 0);
        check(missed_err == 1'b0, "R9 no miss when drained", int'(missed_err), 0);
    endtask

    task automatic t_variable();
        int sum;
        int per;
        do_reset();
        wait_burst_end();
        for (int t = 0; t < NT; t++) write_prof(t, (t == 5) ? 0 : (t % 4) + 1);
        clear_starts();
        wait_burst_end();
        sum = 0;
        for (int i = 0; i < NT; i++) sum += starts[i];
        check(sum == NT, "R11 old counters expire before new profile applies", sum, NT);
        clear_starts();
        repeat (12000) @(negedge clk);
        for (int t = 0; t < NT; t++) begin
            per = (t == 5) ? 1 : (t % 4) + 1;
            if (t == 5)
                check(starts[t] == 12, "R4 zero entry acts as one", starts[t], 12);
            else
                check(starts[t] == 12 / per, "R3 per-tile period", starts[t], 12 / per);
        end
        check(missed_err == 1'b0, "R9 no miss with variable profile", int'(missed_err), 0);
    endtask

    task automatic t_missed();
        int bad;
        logic [LW-1:0] l0;
        do_reset();
        @(posedge clk); #1 req_ready = 1'b0;
        while (!req_valid) @(negedge clk);
        l0 = req_line;
        check(l0 == '0, "R6 first stalled line is zero", int'(l0), 0);
        repeat (2500) @(negedge clk);
        check(req_valid == 1'b1, "R6 valid held while stalled", int'(req_valid), 1);
        check(req_line == l0, "R6 line held while stalled", int'(req_line), int'(l0));
        check(missed_err == 1'b1, "R9 repeat expiry flagged", int'(missed_err), 1);
        @(posedge clk); #1;
        log_n = 0;
        req_ready = 1'b1;
        while (log_n < 512) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 512; i++) if (log_q[i] != i) bad++;
        check(bad == 0, "R9 duplicates not queued", bad, 0);
        repeat (1500) @(negedge clk);
        check(missed_err == 1'b1, "R9 missed flag sticky", int'(missed_err), 1);
    endtask

    task automatic t_overrun();
        do_reset();
        @(posedge clk); #1 div_cfg = 16'd9;
        repeat (300) @(negedge clk);
        check(overrun_err == 1'b1, "R8 tick during sweep flagged", int'(overrun_err), 1);
        @(posedge clk); #1 div_cfg = 16'd999;
        repeat (1500) @(negedge clk);
        check(overrun_err == 1'b1, "R8 overrun flag sticky", int'(overrun_err), 1);
    endtask

    initial begin
        t_reset_state();
        t_baseline();
        t_variable();
        t_missed();
        t_overrun();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule